// File: doc/BRIEF.md
# Word-Programmed Sync Pulse Sequencer

The block plays back a stream of 32-bit timing words from a host-fed FIFO and turns them into a horizontal and vertical sync pin pair. Each word carries four things: the two sync levels, a cycle count and a 16-bit command. The block takes a word, puts its sync levels on the pins and loads the count. It then spends two cycles on the command. After that it holds the pins for count+1 cycles, and it fetches the next word with no idle cycle in between. The host precomputes whole line and frame tables as sequences of such words.

A word lasts exactly count+5 clocks, so the host writes the desired interval minus five into the count field. A command whose top bit is set raises one of the interrupt lines for a single cycle. Software uses these pulses to follow line and frame progress. If the FIFO has no word when one is due, the block stalls with the pins frozen and latches a sticky underflow flag. A parameter selects active-low pins. The inversion sits only in the pin register, so the words always describe active levels.

Top module: `sync_pulse_seq`

## Requirements
- R1: A word is laid out as follows: bit 0 is the horizontal sync level, bit 1 is the vertical sync level, bits 15:2 are the count and bits 31:16 are the command. On the edge that accepts a word, the pins take that word's two sync levels.
- R2: The sync pins change only on an edge that accepts a word. They hold their values through the command, the wait and any stall.
- R3: If a word is always available, consecutive words are accepted exactly count+5 clocks apart. A count of 0 gives 5 clocks and a count of 16383 gives 16388 clocks.
- R4: in_ready is high only while the sequencer waits for a word. It goes low on the cycle after an accept and stays low until the interval of R3 has elapsed.
- R5: If command bit 15 (word bit 31) is set, irq_o[cmd[2:0]] is high for exactly one cycle, starting on the second edge after the accepting edge. No other interrupt line rises.
- R6: A command with bit 15 clear raises no interrupt. This includes 16'h0000 (no-op) and 16'h7FFF. Command bits 14:3 never affect which line pulses.
- R7: If in_ready is high and in_valid is low at an edge, underflow_o is set from that edge on, and only reset clears it. underflow_o stays low while words keep arriving.
- R8: While rst is high and on the first cycle after rst falls, the pins are at their inactive level, irq_o is zero and underflow_o is low. in_ready is low during reset and high on the first cycle after it.
- R9: With SYNC_ACTIVE_LOW=1, each pin carries the inverse of its word bit, and the inactive level after reset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | CNT_W+CMD_W+2 | Timing word from the FIFO |
| in_valid | input | 1 | FIFO holds a word |
| in_ready | output | 1 | Sequencer takes the word on this edge |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| irq_o | output | NUM_IRQ | One-cycle interrupt pulses |
| underflow_o | output | 1 | Sticky FIFO underflow flag |

## Verification
A corrupted phase or counter value shows up at the next accept. in_ready returns a whole number of clocks too early or too late, and the bench measures that against count+5 for every word. A wrong command latch or a misplaced pulse shows on irq_o within three cycles of the accept, as a wrong line, a wrong cycle or a pulse that should not be there. A pin register that is loaded at the wrong time shows in the next negedge sample as a level that differs from the last accepted word.

// File: rtl/sps_pkg.sv
package sps_pkg;
    localparam int SPS_SEL_W    = 3;
    localparam int SPS_OVERHEAD = 5;

    typedef enum logic [2:0] {
        ST_FETCH = 3'd0,
        ST_LOAD  = 3'd1,
        ST_CMD_A = 3'd2,
        ST_CMD_B = 3'd3,
        ST_WAIT  = 3'd4
    } sps_state_e;
endpackage

// File: rtl/sps_word_unpack.sv
module sps_word_unpack import sps_pkg::*; #(
    parameter int CNT_W = 14,
    parameter int CMD_W = 16
) (
    input  logic [CNT_W+CMD_W+1:0]  word,
    output logic                    h_o,
    output logic                    v_o,
    output logic [CNT_W-1:0]        cnt_o,
    output logic                    trig_o,
    output logic [SPS_SEL_W-1:0]    sel_o
);
    localparam int CMD_LO = CNT_W + 2;
    localparam int CMD_HI = CMD_LO + CMD_W - 1;

    logic cmd_unused_bits;

    assign h_o    = word[0];
    assign v_o    = word[1];
    assign cnt_o  = word[CMD_LO-1:2];
    assign trig_o = word[CMD_HI];
    assign sel_o  = word[CMD_LO+SPS_SEL_W-1:CMD_LO];
    // middle command bits select nothing
    assign cmd_unused_bits = ^word[CMD_HI-1:CMD_LO+SPS_SEL_W];
endmodule

// File: rtl/sps_down_counter.sv
module sps_down_counter #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (load) begin
            ctr_d.cnt = load_val;
        end else if (dec) begin
            ctr_d.cnt = ctr_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign zero_o = (ctr_q.cnt == '0);
endmodule

// File: rtl/sps_irq_pulse.sv
module sps_irq_pulse import sps_pkg::*; #(
    parameter int NUM_IRQ = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fire,
    input  logic [SPS_SEL_W-1:0] sel,
    output logic [NUM_IRQ-1:0]   irq_o
);
    typedef struct packed {
        logic [NUM_IRQ-1:0] irq;
    } pulse_t;

    pulse_t pl_d, pl_q;

    always_comb begin
        pl_d.irq = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (fire && (sel == SPS_SEL_W'(i))) begin
                pl_d.irq[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pl_q <= '0;
        end else begin
            pl_q <= pl_d;
        end
    end

    assign irq_o = pl_q.irq;
endmodule

// File: rtl/sps_sync_drive.sv
module sps_sync_drive #(
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic h_i,
    input  logic v_i,
    output logic hsync_o,
    output logic vsync_o
);
    localparam logic [1:0] POL_MASK = {2{ACTIVE_LOW}};

    typedef struct packed {
        logic [1:0] pins;
    } pin_t;

    pin_t pn_d, pn_q;

    always_comb begin
        pn_d = pn_q;
        if (load) begin
            pn_d.pins = {v_i, h_i} ^ POL_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pn_q.pins <= POL_MASK;
        end else begin
            pn_q <= pn_d;
        end
    end

    assign hsync_o = pn_q.pins[0];
    assign vsync_o = pn_q.pins[1];
endmodule

// File: rtl/sync_pulse_seq.sv
module sync_pulse_seq import sps_pkg::*; #(
    parameter int CNT_W           = 14,
    parameter int CMD_W           = 16,
    parameter int NUM_IRQ         = 8,
    parameter bit SYNC_ACTIVE_LOW = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CNT_W+CMD_W+1:0] in_data,
    input  logic                   in_valid,
    output logic                   in_ready,
    output logic                   hsync_o,
    output logic                   vsync_o,
    output logic [NUM_IRQ-1:0]     irq_o,
    output logic                   underflow_o
);
    typedef struct packed {
        sps_state_e             st;
        logic                   ufl;
        logic [CNT_W-1:0]       cnt;
        logic                   trig;
        logic [SPS_SEL_W-1:0]   sel;
    } seq_t;

    seq_t seq_d, seq_q;

    logic                 accept;
    logic                 f_h, f_v, f_trig;
    logic [CNT_W-1:0]     f_cnt;
    logic [SPS_SEL_W-1:0] f_sel;
    logic                 cnt_load, cnt_dec, cnt_zero, irq_fire;

    sps_word_unpack #(.CNT_W(CNT_W), .CMD_W(CMD_W)) u_unpack (
        .word   (in_data),
        .h_o    (f_h),
        .v_o    (f_v),
        .cnt_o  (f_cnt),
        .trig_o (f_trig),
        .sel_o  (f_sel)
    );

    assign in_ready = (seq_q.st == ST_FETCH) && !rst;
    assign accept   = in_ready && in_valid;

    always_comb begin
        seq_d    = seq_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        irq_fire = 1'b0;
        case (seq_q.st)
            ST_FETCH: begin
                if (accept) begin
                    seq_d.cnt  = f_cnt;
                    seq_d.trig = f_trig;
                    seq_d.sel  = f_sel;
                    seq_d.st   = ST_LOAD;
                end else begin
                    seq_d.ufl = 1'b1;
                end
            end
            ST_LOAD: begin
                cnt_load = 1'b1;
                seq_d.st = ST_CMD_A;
            end
            ST_CMD_A: begin
                irq_fire = seq_q.trig;
                seq_d.st = ST_CMD_B;
            end
            ST_CMD_B: begin
                seq_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (cnt_zero) begin
                    seq_d.st = ST_FETCH;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            default: begin
                seq_d.st = ST_FETCH;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.st   <= ST_FETCH;
            seq_q.ufl  <= 1'b0;
            seq_q.cnt  <= '0;
            seq_q.trig <= 1'b0;
            seq_q.sel  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    sps_down_counter #(.W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (seq_q.cnt),
        .dec      (cnt_dec),
        .zero_o   (cnt_zero)
    );

    sps_irq_pulse #(.NUM_IRQ(NUM_IRQ)) u_irq (
        .clk   (clk),
        .rst   (rst),
        .fire  (irq_fire),
        .sel   (seq_q.sel),
        .irq_o (irq_o)
    );

    sps_sync_drive #(.ACTIVE_LOW(SYNC_ACTIVE_LOW)) u_pins (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .h_i     (f_h),
        .v_i     (f_v),
        .hsync_o (hsync_o),
        .vsync_o (vsync_o)
    );

    assign underflow_o = seq_q.ufl;
endmodule

// File: rtl/sps_checker.sv
module sps_checker import sps_pkg::*; #(
    parameter int CNT_W           = 14,
    parameter int CMD_W           = 16,
    parameter int NUM_IRQ         = 8,
    parameter bit SYNC_ACTIVE_LOW = 1'b0
) (
    input logic                   clk,
    input logic                   rst,
    input logic [CNT_W+CMD_W+1:0] in_data,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic                   hsync_o,
    input logic                   vsync_o,
    input logic [NUM_IRQ-1:0]     irq_o,
    input logic                   underflow_o
);
    localparam logic [1:0] POL = {2{SYNC_ACTIVE_LOW}};
    localparam int GW = CNT_W + 2;

    logic             hs;
    logic [CNT_W-1:0] last_q;
    logic [GW-1:0]    gap_q;
    logic             pend_q;

    assign hs = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
            gap_q  <= '0;
            pend_q <= 1'b0;
        end else if (hs) begin
            last_q <= in_data[CNT_W+1:2];
            gap_q  <= GW'(1);
            pend_q <= 1'b1;
        end else begin
            gap_q <= gap_q + GW'(1);
            if (in_ready) begin
                pend_q <= 1'b0;
            end
        end
    end

    AST_SYNC_FROM_WORD: assert property (@(posedge clk) disable iff (rst)
        hs |=> ({vsync_o, hsync_o} == ($past(in_data[1:0]) ^ POL))); // R1
    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !hs |=> $stable({vsync_o, hsync_o})); // R2
    AST_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (in_ready && pend_q) |-> (gap_q == (GW'(last_q) + GW'(SPS_OVERHEAD)))); // R3
    AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
        hs |=> !in_ready); // R4
    AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_o)); // R5
    AST_IRQ_TIMING: assert property (@(posedge clk) disable iff (rst)
        (|irq_o) |-> $past(hs, 3)); // R5
    AST_IRQ_CMD: assert property (@(posedge clk) disable iff (rst)
        (|irq_o) |-> $past(in_data[CNT_W+CMD_W+1], 3)); // R6
    AST_UFL_STICKY: assert property (@(posedge clk) disable iff (rst)
        underflow_o |=> underflow_o); // R7
    AST_UFL_SET: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> underflow_o); // R7
endmodule

bind sync_pulse_seq sps_checker #(
    .CNT_W(CNT_W), .CMD_W(CMD_W), .NUM_IRQ(NUM_IRQ), .SYNC_ACTIVE_LOW(SYNC_ACTIVE_LOW)
) u_sps_chk (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .irq_o(irq_o), .underflow_o(underflow_o)
);

// File: tb/tb_sync_pulse_seq.sv
`timescale 1ns/1ps
module tb_sync_pulse_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        rdy, hs, vs, ufl;
    logic [7:0]  irq;
    logic        rdy_n, hs_n, vs_n, ufl_n;
    logic [7:0]  irq_n;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    int prev_acc = 0;
    int prev_cnt = 0;
    bit have_prev = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sync_pulse_seq #(.SYNC_ACTIVE_LOW(1'b0)) dut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_ready(rdy),
        .hsync_o(hs), .vsync_o(vs), .irq_o(irq), .underflow_o(ufl)
    );

    sync_pulse_seq #(.SYNC_ACTIVE_LOW(1'b1)) dut_n (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_ready(rdy_n),
        .hsync_o(hs_n), .vsync_o(vs_n), .irq_o(irq_n), .underflow_o(ufl_n)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input bit h, input bit v, input int cnt, input logic [15:0] cmd);
        int acc;
        logic [7:0] exp_irq;
        in_data  = {cmd, 14'(cnt), v, h};
        in_valid = 1'b1;
        while (!rdy) @(negedge clk);
        acc = cyc + 1;
        if (have_prev)
            chk(acc - prev_acc == prev_cnt + 5, "R3 interval", acc - prev_acc, prev_cnt + 5);
        prev_acc  = acc;
        prev_cnt  = cnt;
        have_prev = 1'b1;
        exp_irq = cmd[15] ? 8'(1 << cmd[2:0]) : 8'h00;
        @(negedge clk);
        chk({vs, hs} == {v, h}, "R1 pins after accept", {vs, hs}, {v, h});
        chk({vs_n, hs_n} == ~{v, h}, "R9 inverted pins", {vs_n, hs_n}, ~{v, h});
        chk(!rdy && !rdy_n, "R4 ready low after accept", rdy, 0);
        chk(irq == 0, "R5 no early pulse", irq, 0);
        @(negedge clk);
        chk(irq == 0, "R5 no early pulse", irq, 0);
        chk(!rdy, "R4 ready low", rdy, 0);
        @(negedge clk);
        chk(irq == exp_irq, "R5 R6 pulse line", irq, exp_irq);
        chk(irq_n == exp_irq, "R9 irq unaffected by polarity", irq_n, exp_irq);
        @(negedge clk);
        chk(irq == 0, "R5 single cycle pulse", irq, 0);
        chk({vs, hs} == {v, h}, "R2 pins held", {vs, hs}, {v, h});
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R3 actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        in_valid = 1'b1;
        in_data  = '0;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk({vs, hs} == 2'b00, "R8 pins inactive in reset", {vs, hs}, 0);
        chk({vs_n, hs_n} == 2'b11, "R9 active-low inactive level", {vs_n, hs_n}, 3);
        chk(irq == 0 && ufl == 0 && ufl_n == 0, "R8 flags clear in reset", {irq, ufl}, 0);
        chk(rdy == 0, "R8 ready low in reset", rdy, 0);
        rst = 1'b0;
        #1;
        chk(rdy == 1, "R8 ready after reset", rdy, 1);

        for (int i = 0; i < 256; i++) begin
            logic [15:0] cmd;
            case (i % 4)
                0: cmd = 16'h8000 | 16'((i / 4) % 8);
                1: cmd = 16'h0000;
                2: cmd = 16'h7FFF;
                default: cmd = 16'hFFF8 | 16'(((i / 4) + 3) % 8);
            endcase
            push(i[0], i[1], i / 4, cmd);
        end
        chk(ufl == 0, "R7 no underflow while fed", ufl, 0);

        // R3 longest count
        push(1'b0, 1'b1, 16383, 16'h8005);
        push(1'b1, 1'b0, 0, 16'h0000);
        chk(ufl == 0, "R7 no underflow while fed", ufl, 0);

        // R7 stall with empty FIFO
        in_valid = 1'b0;
        while (!rdy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(ufl == 1, "R7 underflow set", ufl, 1);
        chk({vs, hs} == 2'b01, "R2 pins held in stall", {vs, hs}, 1);
        chk(irq == 0, "R6 no pulse in stall", irq, 0);
        have_prev = 1'b0;
        push(1'b0, 1'b1, 3, 16'h8002);
        chk(ufl == 1, "R7 underflow sticky", ufl, 1);

        // R8 second reset clears flags and pins
        rst = 1'b1;
        @(negedge clk);
        chk(ufl == 0, "R8 reset clears underflow", ufl, 0);
        chk({vs, hs} == 2'b00, "R8 reset pins inactive", {vs, hs}, 0);
        chk({vs_n, hs_n} == 2'b11, "R9 reset pins high", {vs_n, hs_n}, 3);
        rst = 1'b0;
        have_prev = 1'b0;
        push(1'b1, 1'b1, 2, 16'h8007);
        push(1'b0, 1'b0, 1, 16'h0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule